// File: doc/BRIEF.md
# Multistream time-shared polyphase decimator

This block lowers the sample rate of four independent signed streams by a factor of four. All four streams run through one set of four polyphase computation units and one final adder, not one filter per stream. Every stream enters at full rate. Per stream, a commutator deals successive samples to the phase subfilters in a fixed rotation. Each stream path carries its own fixed delay of 0 to 3 stages, so the streams reach the end of their four-sample blocks in successive clocks. In each clock the shared units therefore work on exactly one stream's block.

The sum of the four phase outputs is one full-precision decimated sample. An output commutator writes it to the register of the stream it belongs to and pulses that stream's valid strobe. The coefficients are fixed at elaboration. Every constant multiplier is built from shifted copies of its input that are added or subtracted according to the coefficient's canonic signed-digit form.

Top module: `mspd_decimator`

## Requirements
- R1: While rst_n is low at a clock edge, all outputs and all strobes clear to zero. Cycle 0 is the first cycle in which rst_n is high, and in cycle 0 every dout lane reads 0 and dout_vld is 0.
- R2: Let stream s present sample x_s[j] in cycle j. Stream s's k-th output is y_s[k] = sum over n=0..15 of h[n]*x_s[4k+3-n], where samples before index 0 count as zero. The default taps h[0..15] are -23, -96, -151, 64, 517, 1290, 2811, 4095, 4095, 2811, 1290, 517, 64, -151, -96, -23.
- R3: Sample index j of a stream goes to phase 3-(j mod 4), starting at phase 3 for index 0. Phase m applies taps h(4i+m). The kept samples therefore always end a block at index 4k+3, whatever the data.
- R4: dout_vld[s] is high exactly in cycles 4k+5+s for k >= 0, and dout lane s then carries y_s[k].
- R5: From cycle 5 on, exactly one strobe is high in each cycle. The strobes rotate through streams 0, 1, 2, 3 (A' to D') and back to 0.
- R6: A dout lane changes only in a cycle in which its strobe is high, and it holds its value in all other cycles.
- R7: Outputs are 27-bit two's complement and exact. Full-scale constant inputs of 511 or -512, and full-scale alternating inputs, give the exact filter sum without wrap.
- R8: The streams are independent. A nonzero input on one stream leaves the outputs of all other streams at zero.
- R9: Every constant multiplier gives the exact product of its 10-bit input and its 13-bit coefficient.
- R10: A reset in the middle of a run, at any rotation position, clears the stored history and restarts the rotation at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 40 | Four 10-bit signed input samples, stream s in bits [10s+9:10s] |
| dout | output | 108 | Four 27-bit signed decimated samples, stream s in bits [27s+26:27s] |
| dout_vld | output | 4 | Per-stream strobe, high for the cycle in which a new sample appears |

## Verification
The hard case to reach from the ports is tying one coefficient, inside the shared units, to one stream. The stagger means a given unit serves a different stream in each clock. A dense input mixes every tap into every output, so a wrong pairing of tap, stream and phase can stay hidden. The stimulus therefore drives a single impulse on one stream at a time, at each of the four offsets within a block. This puts each group of four coefficients, in turn, alone on one stream's output and leaves the other three streams at zero. Runs of different lengths, each ending in a reset, make the reset land at every rotation position.

// File: rtl/mspd_pkg.sv
// Shared constants and elaboration-time helpers for the multistream decimator.
// Assumes: default geometry of four phases with four taps each.
package mspd_pkg;

    localparam int PHASES         = 4;
    localparam int TAPS_PER_PHASE = 4;
    localparam int IN_W           = 10;
    localparam int COEF_W         = 13;

    // Default low-pass prototype, 13-bit signed range.
    localparam int DEF_COEF [PHASES*TAPS_PER_PHASE] = '{
        -23, -96, -151, 64, 517, 1290, 2811, 4095,
        4095, 2811, 1290, 517, 64, -151, -96, -23
    };

    // Canonic signed-digit recoding: returns the digit (-1, 0, +1) at weight 2**pos.
    function automatic int csd_digit(input int c, input int pos);
        int v;
        int d;
        v = c;
        d = 0;
        for (int i = 0; i <= pos; i++) begin
            if ((v & 1) != 0) begin
                d = ((v & 3) == 1) ? 1 : -1;
            end else begin
                d = 0;
            end
            v = (v - d) >>> 1;
        end
        return d;
    endfunction

endpackage

// File: rtl/mspd_csd_mult.sv
// Constant multiplier built from shifted, added and subtracted copies of x.
// Assumes: COEF fits in CW signed bits; the product fits in XW+CW bits.
module mspd_csd_mult #(
    parameter int XW   = 10,
    parameter int CW   = 13,
    parameter int COEF = 1,
    localparam int PW  = XW + CW,
    localparam int ND  = CW + 1
) (
    input  logic signed [XW-1:0] x,
    output logic signed [PW-1:0] p
);

    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] terms [ND];

    assign xe = {{CW{x[XW-1]}}, x};

    for (genvar g = 0; g < ND; g++) begin : g_digit
        localparam int D = mspd_pkg::csd_digit(COEF, g);
        if (D > 0) begin : g_pos
            assign terms[g] = xe <<< g;
        end else if (D < 0) begin : g_neg
            assign terms[g] = -(xe <<< g);
        end else begin : g_zero
            assign terms[g] = '0;
        end
    end

    // Adder tree over the nonzero signed digits.
    always_comb begin
        p = '0;
        for (int i = 0; i < ND; i++) begin
            p = p + terms[i];
        end
    end

endmodule

// File: rtl/mspd_phase_unit.sv
// One shared polyphase computation unit: dot product of L taps with h(iM+PH).
// Assumes: the taps belong to whichever stream the top has selected this cycle.
module mspd_phase_unit #(
    parameter int M  = 4,
    parameter int L  = 4,
    parameter int XW = 10,
    parameter int CW = 13,
    parameter int PH = 0,
    parameter int COEF [M*L] = mspd_pkg::DEF_COEF,
    localparam int PW = XW + CW,
    localparam int SW = PW + $clog2(L)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [XW-1:0] taps [L],
    output logic signed [SW-1:0] acc
);

    logic signed [PW-1:0] prod [L];
    logic signed [SW-1:0] ref_acc;

    for (genvar i = 0; i < L; i++) begin : g_tap
        mspd_csd_mult #(
            .XW  (XW),
            .CW  (CW),
            .COEF(COEF[i*M+PH])
        ) u_mult (
            .x(taps[i]),
            .p(prod[i])
        );
    end

    // Sum of the per-tap products at full width.
    always_comb begin
        acc = '0;
        for (int i = 0; i < L; i++) begin
            acc = acc + SW'(prod[i]);
        end
    end

    // Independent multiply-based reference for the shift-add network.
    always_comb begin
        ref_acc = '0;
        for (int i = 0; i < L; i++) begin
            ref_acc = ref_acc + SW'(taps[i]) * SW'(COEF[i*M+PH]);
        end
    end

    // R9
    csd_match_chk: assert property (@(posedge clk) disable iff (!rst_n) acc == ref_acc);

endmodule

// File: rtl/mspd_lane.sv
// Per-stream input path: fixed stagger delay, input commutator and one
// decimated-rate delay line per phase.
// Assumes: cnt is the shared mod-M rotation counter, zero in the first cycle.
module mspd_lane #(
    parameter int M   = 4,
    parameter int L   = 4,
    parameter int XW  = 10,
    parameter int DLY = 0,
    localparam int CNTW = $clog2(M)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNTW-1:0]      cnt,
    input  logic signed [XW-1:0] din,
    output logic signed [XW-1:0] taps [M][L]
);

    logic signed [XW-1:0] dly_out;
    logic [M-1:0]         wr_en;
    int                   rel;

    if (DLY == 0) begin : g_nodly
        assign dly_out = din;
    end else begin : g_dly
        logic signed [XW-1:0] sr [DLY];
        // Stagger register chain that offsets this stream's block boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DLY; i++) sr[i] <= '0;
            end else begin
                sr[0] <= din;
                for (int i = 1; i < DLY; i++) sr[i] <= sr[i-1];
            end
        end
        assign dly_out = sr[DLY-1];
    end

    // Commutator: the sample entering now goes to phase M-1-(index mod M).
    always_comb begin
        rel   = (int'(cnt) - DLY + M) % M;
        wr_en = '0;
        for (int p = 0; p < M; p++) begin
            if (p == M - 1 - rel) wr_en[p] = 1'b1;
        end
    end

    // Per-phase delay lines shift only when their phase receives a sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < M; p++)
                for (int i = 0; i < L; i++) taps[p][i] <= '0;
        end else begin
            for (int p = 0; p < M; p++) begin
                if (wr_en[p]) begin
                    taps[p][0] <= dly_out;
                    for (int i = 1; i < L; i++) taps[p][i] <= taps[p][i-1];
                end
            end
        end
    end

    for (genvar p = 0; p < M; p++) begin : g_chk
        // R3
        phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[p] |=> taps[p][0] == $past(dly_out));
        // R3
        phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[p] |=> $stable(taps[p][0]));
    end

endmodule

// File: rtl/mspd_decimator.sv
// Top: four streams decimated by M through one shared set of M phase units.
// Stream s is delayed s cycles so its block completes in cycle Mk+M+s; the
// shared units serve stream (cycle mod M) and the result is steered to it.
// Assumes: synchronous active-low reset; cycle 0 is the first cycle out of reset.
module mspd_decimator #(
    parameter int M  = mspd_pkg::PHASES,
    parameter int L  = mspd_pkg::TAPS_PER_PHASE,
    parameter int XW = mspd_pkg::IN_W,
    parameter int CW = mspd_pkg::COEF_W,
    parameter int COEF [M*L] = mspd_pkg::DEF_COEF,
    localparam int CNTW = $clog2(M),
    localparam int PW   = XW + CW,
    localparam int SW   = PW + $clog2(L),
    localparam int YW   = PW + $clog2(M*L)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [M*XW-1:0] din,
    output logic [M*YW-1:0] dout,
    output logic [M-1:0]    dout_vld
);

    logic [CNTW-1:0]      cnt;
    logic                 warm;
    logic signed [XW-1:0] all_taps [M][M][L];
    logic signed [XW-1:0] cu_taps  [M][L];
    logic signed [SW-1:0] cu_acc   [M];
    logic signed [YW-1:0] total;
    logic signed [YW-1:0] dout_q   [M];
    logic [M-1:0]         vld_q;

    // Rotation counter shared by all commutators; warm marks the first full block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            warm <= 1'b0;
        end else begin
            cnt  <= (int'(cnt) == M - 1) ? '0 : cnt + 1'b1;
            warm <= warm | (int'(cnt) == M - 1);
        end
    end

    for (genvar s = 0; s < M; s++) begin : g_lane
        mspd_lane #(
            .M  (M),
            .L  (L),
            .XW (XW),
            .DLY(s)
        ) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .cnt  (cnt),
            .din  (din[s*XW +: XW]),
            .taps (all_taps[s])
        );
    end

    // Shared-unit input select: this cycle's stream is the one whose block just closed.
    always_comb begin
        for (int m = 0; m < M; m++)
            for (int i = 0; i < L; i++)
                cu_taps[m][i] = all_taps[cnt][m][i];
    end

    for (genvar m = 0; m < M; m++) begin : g_cu
        mspd_phase_unit #(
            .M   (M),
            .L   (L),
            .XW  (XW),
            .CW  (CW),
            .PH  (m),
            .COEF(COEF)
        ) u_cu (
            .clk  (clk),
            .rst_n(rst_n),
            .taps (cu_taps[m]),
            .acc  (cu_acc[m])
        );
    end

    // Final adder across the phase units.
    always_comb begin
        total = '0;
        for (int m = 0; m < M; m++) total = total + YW'(cu_acc[m]);
    end

    // Output commutator: register the sum on the served stream and pulse its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < M; s++) dout_q[s] <= '0;
            vld_q <= '0;
        end else begin
            vld_q <= '0;
            if (warm) begin
                dout_q[cnt] <= total;
                vld_q[cnt]  <= 1'b1;
            end
        end
    end

    assign dout_vld = vld_q;
    for (genvar s = 0; s < M; s++) begin : g_out
        assign dout[s*YW +: YW] = dout_q[s];

        // R5
        strobe_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[s] |=> vld_q[(s+1)%M]);
        // R4
        strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[s] |=> !vld_q[s]);
        // R6
        hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_q[s] |-> $stable(dout_q[s]));
    end

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld_q));

endmodule

// File: tb/tb_mspd_decimator.sv
// Sweeps impulse, full-scale, alternating, ramp and pseudo-random patterns over
// all four streams; every output cycle is compared with a full-rate filter model.
module tb_mspd_decimator;

    localparam int M  = 4;
    localparam int NT = 16;
    localparam int XW = 10;
    localparam int YW = 27;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [M*XW-1:0] din = '0;
    logic [M*YW-1:0] dout;
    logic [M-1:0]    dout_vld;

    int     coef [NT] = '{-23, -96, -151, 64, 517, 1290, 2811, 4095,
                          4095, 2811, 1290, 517, 64, -151, -96, -23};
    int     hist [M][0:511];
    longint last_out [M];
    int     n_chk = 0;
    int     n_fail = 0;

    always #5 clk = ~clk;

    mspd_decimator dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .dout    (dout),
        .dout_vld(dout_vld)
    );

    function automatic int gen(input int pat, input int s, input int j);
        int h;
        case (pat)
            0, 1, 2, 3: return (s == pat && j == pat + 4) ? ((s % 2 == 0) ? 300 : -300) : 0;
            4:          return 511;
            5:          return -512;
            6:          return (((j + s) % 2) == 0) ? 511 : -512;
            7:          return ((j * (s + 3)) % 1024) - 512;
            default: begin
                h = j * 1103515245 + s * 12345 + 777;
                return ((h >>> 7) & 1023) - 512;
            end
        endcase
    endfunction

    function automatic longint model(input int s, input int k);
        longint acc = 0;
        for (int n = 0; n < NT; n++) begin
            if (4*k + 3 - n >= 0) acc += longint'(coef[n]) * longint'(hist[s][4*k+3-n]);
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run(input int pat, input int ncyc);
        longint got;
        bit     exp_v;
        rst_n = 1'b0;
        din   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < ncyc; t++) begin
            if (t > 0) @(negedge clk);
            for (int s = 0; s < M; s++) begin
                hist[s][t] = gen(pat, s, t);
                din[s*XW +: XW] = XW'(hist[s][t]);
            end
            for (int s = 0; s < M; s++) begin
                got = longint'($signed(dout[s*YW +: YW]));
                if (t == 0) begin
                    // R1 / R10: cleared after reset, even from a dirty state
                    check(dout_vld[s] == 1'b0, "R1 strobe after reset", longint'(dout_vld[s]), 0);
                    check(got == 0, "R10 output after reset", got, 0);
                    last_out[s] = 0;
                end else begin
                    exp_v = (t >= 5 + s) && (((t - 5 - s) % 4) == 0);
                    check(dout_vld[s] == exp_v, "R4/R5 strobe timing", longint'(dout_vld[s]), longint'(exp_v));
                    if (exp_v) begin
                        // R2 R3 R7 R8 R9: exact filter value for this stream
                        check(got == model(s, (t - 5 - s) / 4), "R2 decimated value", got, model(s, (t - 5 - s) / 4));
                        last_out[s] = got;
                    end else begin
                        check(got == last_out[s], "R6 hold between strobes", got, last_out[s]);
                    end
                end
            end
        end
    endtask

    initial begin
        for (int p = 0; p < 4; p++) run(p, 45 + p);  // R8 R3: isolated impulses
        run(4, 61);                                  // R7 full-scale positive
        run(5, 62);                                  // R7 full-scale negative
        run(6, 63);                                  // R7 alternating extremes
        run(7, 90);                                  // ramp
        run(8, 150);                                 // pseudo-random, R10 via prior runs
        run(8, 7);                                   // short run then reset mid-block
        run(6, 40);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule